// File: doc/BRIEF.md
# I2C Segment Repeater

This block joins one I2C master segment to one of several downstream segments using logic alone, with no pass transistors and no sensing of drive current. Every wire is open-drain, so each segment line appears as a sampled input level and an active-high pull-down output. Outside the block, the board turns the pull-down into a transistor that sinks the line.

Each clock-low phase starts when the master is seen pulling SCL low. The block then pulls SCL low on both segments for a fixed number of system clocks. After that it lets the downstream SCL go and makes the master-side pull-down follow the downstream level. A slave that holds SCL low therefore stretches the master's clock, on any bit.

SDA direction comes from decoding the bus traffic. The decoder tracks START and STOP, counts bits, reads the R/W bit of the address byte and finds the acknowledge slots. The downstream segment is chosen by a select input, which is only taken while the bus is idle.

Top module: `i2c_seg_repeater`

## Requirements
- R1: After reset, every pull-down output (master and all downstream segments, SCL and SDA) is deasserted.
- R2: When the filtered master SCL falls, the block asserts the master SCL pull-down and the selected segment's SCL pull-down in the same cycle. The segment pull-down stays asserted for exactly HOLD_CYC clock cycles, and the master pull-down stays asserted throughout that window.
- R3: Once the hold window ends, the master SCL pull-down follows the sampled selected-segment SCL. A slave that keeps SCL low keeps the master side low. The master side is released a few cycles after the slave releases.
- R4: Bytes are sent MSB first, and the eighth bit of the address byte is R/W (1 = read). In the address byte and in write data bytes, the eight data bits go master to segment and the ninth (acknowledge) bit goes segment to master.
- R5: After an acknowledged read address, the eight data bits of each byte go segment to master and the acknowledge bit goes master to segment.
- R6: If the master leaves SDA high in a read byte's acknowledge slot (NACK), read forwarding ends. A slave pulling SDA low after that no longer reaches the master's pull-down until the next START.
- R7: A START (SDA falls while SCL is high) puts the decoder back in the address phase from any state, including a repeated START in the middle of a transfer. A STOP (SDA rises while SCL is high) returns it to idle.
- R8: The select input is taken only while the decoder is idle, meaning after reset or a STOP and before the next START. Only the latched segment ever gets a pull-down, and changing the select during a transfer has no effect until that transfer's STOP.
- R9: Every sampled input passes two synchronizing flip-flops and a filter that accepts a new level only after FILT consecutive cycles. A master SCL low glitch shorter than FILT cycles causes no pull-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_sel | input | SEL_W | Downstream segment select, taken when the bus is idle |
| m_scl_i | input | 1 | Sampled master-segment SCL level |
| m_sda_i | input | 1 | Sampled master-segment SDA level |
| m_scl_pd | output | 1 | Pull master-segment SCL low |
| m_sda_pd | output | 1 | Pull master-segment SDA low |
| s_scl_i | input | NSEG | Sampled SCL level of each downstream segment |
| s_sda_i | input | NSEG | Sampled SDA level of each downstream segment |
| s_scl_pd | output | NSEG | Pull each downstream segment's SCL low |
| s_sda_pd | output | NSEG | Pull each downstream segment's SDA low |

## Verification
The bench models both segments as wired-AND lines. It sweeps clock-low phases and transfers across every segment, and for each bit it compares the levels at both ends with the level of whichever side should be driving.

The hold window is measured to the exact cycle, so an off-by-one timer shows up as the wrong length. A slave that stretches long past the window must keep the master low; a repeater that freed the master early would let it clock ahead. The acknowledge slot of the address, write and read bytes is where a wrong bit counter or a misread R/W bit would leave one end floating high.

A read ended by NACK is followed by a slave pulling SDA low; a decoder that stayed in read forwarding would pass that low back to the master. Further cases are a repeated START straight after write data, a select change in the middle of a transfer (it must not move the pull-downs), and a short SCL glitch that a missing filter would turn into a full hold window.

// File: rtl/i2c_seg_repeater.sv
module i2c_seg_repeater #(
  parameter int NSEG     = 4,
  parameter int HOLD_CYC = 400,
  parameter int FILT     = 3,
  parameter int SEL_W    = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] seg_sel,
  input  logic             m_scl_i,
  input  logic             m_sda_i,
  output logic             m_scl_pd,
  output logic             m_sda_pd,
  input  logic [NSEG-1:0]  s_scl_i,
  input  logic [NSEG-1:0]  s_sda_i,
  output logic [NSEG-1:0]  s_scl_pd,
  output logic [NSEG-1:0]  s_sda_pd
);
  localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam int FW = (FILT > 1) ? $clog2(FILT) : 1;

  typedef enum logic [1:0] {C_IDLE, C_HOLD, C_FOLLOW} clk_st_t;
  typedef enum logic [2:0] {P_IDLE, P_ADDR, P_WR, P_RD, P_WAIT} ph_t;

  logic [SEL_W-1:0] sel_q;
  logic [1:0]       m_scl_sy, m_sda_sy;
  logic [NSEG-1:0]  s_scl_s1, s_scl_s2, s_sda_s1, s_sda_s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_scl_sy <= '1;
      m_sda_sy <= '1;
      s_scl_s1 <= '1;
      s_scl_s2 <= '1;
      s_sda_s1 <= '1;
      s_sda_s2 <= '1;
    end else begin
      m_scl_sy <= {m_scl_sy[0], m_scl_i};
      m_sda_sy <= {m_sda_sy[0], m_sda_i};
      s_scl_s1 <= s_scl_i;
      s_scl_s2 <= s_scl_s1;
      s_sda_s1 <= s_sda_i;
      s_sda_s2 <= s_sda_s1;
    end

  // channel order: 0 master SCL, 1 master SDA, 2 segment SCL, 3 segment SDA
  logic [3:0] raw, flt, flt_d;
  assign raw = {s_sda_s2[sel_q], s_scl_s2[sel_q], m_sda_sy[1], m_scl_sy[1]};

  for (genvar i = 0; i < 4; i++) begin : g_flt
    logic          lvl;
    logic [FW-1:0] run;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        lvl <= 1'b1;
        run <= '0;
      end else if (raw[i] == lvl) begin
        run <= '0;
      end else if (run == FW'(FILT - 1)) begin
        lvl <= raw[i];
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    assign flt[i] = lvl;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flt_d <= '1;
    else        flt_d <= flt;

  logic scl_fall, scl_rise, scl_hi, dir_s2m, start_ev, stop_ev;
  assign scl_fall = flt_d[0] & ~flt[0];
  assign scl_rise = ~flt_d[0] & flt[0];
  assign scl_hi   = flt_d[0] & flt[0];
  assign start_ev = scl_hi & ~dir_s2m & flt_d[1] & ~flt[1];
  assign stop_ev  = scl_hi & ~dir_s2m & ~flt_d[1] & flt[1];

  clk_st_t       cst;
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cst  <= C_IDLE;
      hcnt <= '0;
    end else begin
      case (cst)
        C_IDLE:   if (scl_fall) begin cst <= C_HOLD; hcnt <= '0; end
        C_HOLD:   if (hcnt == HW'(HOLD_CYC - 1)) cst <= C_FOLLOW;
                  else hcnt <= hcnt + 1'b1;
        C_FOLLOW: if (flt[2] && flt[0]) cst <= C_IDLE;
        default:  cst <= C_IDLE;
      endcase
    end

  ph_t        ph;
  logic [3:0] bcnt;
  logic       bit_seen, rw, nack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph       <= P_IDLE;
      bcnt     <= '0;
      bit_seen <= 1'b0;
      rw       <= 1'b0;
      nack     <= 1'b0;
    end else if (start_ev) begin
      ph       <= P_ADDR;
      bcnt     <= '0;
      bit_seen <= 1'b0;
    end else if (stop_ev) begin
      ph       <= P_IDLE;
      bcnt     <= '0;
      bit_seen <= 1'b0;
    end else if (scl_rise && (ph == P_ADDR || ph == P_WR || ph == P_RD)) begin
      bit_seen <= 1'b1;
      if (ph == P_ADDR && bcnt == 4'd7) rw   <= flt[1];
      if (ph == P_RD   && bcnt == 4'd8) nack <= flt[1];
    end else if (scl_fall && bit_seen) begin
      bit_seen <= 1'b0;
      if (bcnt == 4'd8) begin
        bcnt <= '0;
        if (ph == P_ADDR)           ph <= rw ? P_RD : P_WR;
        else if (ph == P_RD && nack) ph <= P_WAIT;
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end

  always_comb
    case (ph)
      P_ADDR, P_WR: dir_s2m = (bcnt == 4'd8);
      P_RD:         dir_s2m = (bcnt != 4'd8);
      default:      dir_s2m = 1'b0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      sel_q <= '0;
    else if (ph == P_IDLE && !start_ev) sel_q <= seg_sel;

  assign m_scl_pd = (cst == C_HOLD) | ((cst == C_FOLLOW) & ~flt[2]);
  assign m_sda_pd = dir_s2m & ~flt[3];

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    assign s_scl_pd[k] = (cst == C_HOLD) & (sel_q == SEL_W'(k));
    assign s_sda_pd[k] = ~dir_s2m & ~flt[1] & (sel_q == SEL_W'(k));
  end
endmodule

// File: rtl/i2c_seg_repeater_chk.sv
module i2c_seg_repeater_chk #(
  parameter int NSEG     = 4,
  parameter int HOLD_CYC = 400
) (
  input logic            clk,
  input logic            rst_n,
  input logic            m_scl_pd,
  input logic            m_sda_pd,
  input logic [NSEG-1:0] s_scl_pd,
  input logic [NSEG-1:0] s_sda_pd
);
  int unsigned hold_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           hold_run <= 0;
    else if (!(|s_scl_pd)) hold_run <= 0;
    else if (hold_run < HOLD_CYC + 4) hold_run <= hold_run + 1;

  // R2
  hold_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|s_scl_pd) |-> m_scl_pd);
  // R2
  hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|s_scl_pd) |-> $rose(m_scl_pd));
  // R2
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_run <= HOLD_CYC);
  // R8
  seg_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_scl_pd));
  // R8
  seg_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_sda_pd));
  // R4
  sda_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_sda_pd && (|s_sda_pd)));
endmodule

bind i2c_seg_repeater i2c_seg_repeater_chk #(.NSEG(NSEG), .HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_scl_pd(m_scl_pd), .m_sda_pd(m_sda_pd),
  .s_scl_pd(s_scl_pd), .s_sda_pd(s_sda_pd)
);

// File: tb/tb_i2c_seg_repeater.sv
`timescale 1ns/1ps
module tb_i2c_seg_repeater;
  localparam int NSEG = 4;
  localparam int HOLD = 20;
  localparam int FILT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] seg_sel = '0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic [NSEG-1:0] sl_scl_low = '0, sl_sda_low = '0;
  logic m_scl_i, m_sda_i, m_scl_pd, m_sda_pd;
  logic [NSEG-1:0] s_scl_i, s_sda_i, s_scl_pd, s_sda_pd;

  always #10 clk = ~clk;

  assign m_scl_i = ~m_scl_low & ~m_scl_pd;
  assign m_sda_i = ~m_sda_low & ~m_sda_pd;
  assign s_scl_i = ~sl_scl_low & ~s_scl_pd;
  assign s_sda_i = ~sl_sda_low & ~s_sda_pd;

  i2c_seg_repeater #(.NSEG(NSEG), .HOLD_CYC(HOLD), .FILT(FILT)) dut (
    .clk(clk), .rst_n(rst_n), .seg_sel(seg_sel),
    .m_scl_i(m_scl_i), .m_sda_i(m_sda_i), .m_scl_pd(m_scl_pd), .m_sda_pd(m_sda_pd),
    .s_scl_i(s_scl_i), .s_sda_i(s_sda_i), .s_scl_pd(s_scl_pd), .s_sda_pd(s_sda_pd)
  );

  int checks = 0, fails = 0, stray = 0;
  logic [NSEG-1:0] exp_mask = '1;
  bit ended = 0;

  always @(negedge clk)
    if (rst_n && (((s_scl_pd | s_sda_pd) & ~exp_mask) != '0)) stray++;

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_hi();
    while (!m_scl_i) @(negedge clk);
  endtask

  task automatic mbit(input bit mb, input bit sb, input int seg, output bit mv, output bit sv);
    m_scl_low = 1'b1;
    waitc(10);
    m_sda_low = ~mb;
    sl_sda_low[seg] = ~sb;
    waitc(4);
    m_scl_low = 1'b0;
    wait_scl_hi();
    waitc(8);
    mv = m_sda_i;
    sv = s_sda_i[seg];
    waitc(4);
  endtask

  task automatic xbyte(input logic [7:0] d, input bit from_m, input bit ack,
                       input int seg, input string rq, input string rq_ack);
    bit mv, sv;
    for (int i = 7; i >= 0; i--) begin
      mbit(from_m ? d[i] : 1'b1, from_m ? 1'b1 : d[i], seg, mv, sv);
      chk(mv == d[i] && sv == d[i], rq, {mv, sv}, {d[i], d[i]});
    end
    mbit(from_m ? 1'b1 : ack, from_m ? ack : 1'b1, seg, mv, sv);
    chk(mv == ack && sv == ack, rq_ack, {mv, sv}, {ack, ack});
  endtask

  task automatic bus_start();
    m_sda_low = 1'b1;
    waitc(15);
  endtask

  task automatic bus_stop();
    m_scl_low = 1'b1;
    waitc(10);
    m_sda_low = 1'b1;
    sl_sda_low = '0;
    waitc(4);
    m_scl_low = 1'b0;
    wait_scl_hi();
    waitc(10);
    m_sda_low = 1'b0;
    waitc(20);
  endtask

  task automatic bus_rstart();
    m_scl_low = 1'b1;
    waitc(10);
    m_sda_low = 1'b0;
    sl_sda_low = '0;
    waitc(4);
    m_scl_low = 1'b0;
    wait_scl_hi();
    waitc(10);
    m_sda_low = 1'b1;
    waitc(15);
  endtask

  task automatic scl_phase(input int seg, input bit slave_hold);
    int t, n, mm;
    t = 0; n = 0; mm = 0;
    sl_scl_low[seg] = slave_hold;
    m_scl_low = 1'b1;
    while (!s_scl_pd[seg] && t < 50) begin waitc(1); t++; end
    while (s_scl_pd[seg] && n < 1000) begin
      if (!m_scl_pd) mm++;
      waitc(1);
      n++;
    end
    chk(n == HOLD, "R2 segment hold length", n, HOLD);
    chk(mm == 0, "R2 master held during window", mm, 0);
    if (slave_hold) begin
      waitc(40);
      chk(m_scl_pd == 1'b1, "R3 slave stretch reaches master", m_scl_pd, 1);
      sl_scl_low[seg] = 1'b0;
    end
    waitc(12);
    chk(m_scl_pd == 1'b0, "R3 master freed after slave high", m_scl_pd, 0);
    m_scl_low = 1'b0;
    wait_scl_hi();
    waitc(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int cnt;
    waitc(5);
    rst_n = 1'b1;
    waitc(3);
    // R1 reset state
    chk(m_scl_pd == 0 && m_sda_pd == 0, "R1 master pull-downs", {m_scl_pd, m_sda_pd}, 0);
    chk(s_scl_pd == 0 && s_sda_pd == 0, "R1 segment pull-downs", {s_scl_pd, s_sda_pd}, 0);

    // R9 glitch shorter than the filter
    seg_sel = 2'd0; exp_mask = 4'b0001;
    waitc(5);
    m_scl_low = 1'b1; waitc(FILT - 1); m_scl_low = 1'b0;
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      if (s_scl_pd != 0 || m_scl_pd) cnt++;
      waitc(1);
    end
    chk(cnt == 0, "R9 short SCL glitch ignored", cnt, 0);

    // R2/R3 clock-low phases on every segment, with and without stretch
    for (int s = 0; s < NSEG; s++) begin
      seg_sel = 2'(s); exp_mask = 4'(1 << s);
      waitc(5);
      scl_phase(s, s[0]);
    end

    // R4 write transfers swept over segments
    for (int s = 0; s < NSEG; s++) begin
      seg_sel = 2'(s); exp_mask = 4'(1 << s); stray = 0;
      waitc(5);
      bus_start();
      xbyte({7'h50 + 7'(s), 1'b0}, 1'b1, 1'b0, s, "R4 address bit", "R4 address ack");
      xbyte(8'h5A ^ 8'(s * 51), 1'b1, 1'b0, s, "R4 write bit", "R4 write ack");
      bus_stop();
      chk(stray == 0, "R8 only selected segment pulled", stray, 0);
    end

    // R8 select change mid-transfer is ignored until STOP
    seg_sel = 2'd1; exp_mask = 4'b0010; stray = 0;
    waitc(5);
    bus_start();
    xbyte(8'hA0, 1'b1, 1'b0, 1, "R4 address bit", "R4 address ack");
    seg_sel = 2'd3;
    xbyte(8'h69, 1'b1, 1'b0, 1, "R8 data stays on old segment", "R8 ack on old segment");
    bus_stop();
    chk(stray == 0, "R8 no pull on new segment mid-transfer", stray, 0);
    exp_mask = 4'b1000; stray = 0;
    waitc(5);
    bus_start();
    xbyte(8'hA2, 1'b1, 1'b0, 3, "R8 new segment after STOP", "R8 new segment ack");
    bus_stop();
    chk(stray == 0, "R8 new segment only", stray, 0);

    // R5/R6 read with master ACK then NACK
    seg_sel = 2'd0; exp_mask = 4'b0001;
    waitc(5);
    bus_start();
    xbyte({7'h2D, 1'b1}, 1'b1, 1'b0, 0, "R4 read address bit", "R4 read address ack");
    xbyte(8'hA5, 1'b0, 1'b0, 0, "R5 read data bit", "R5 master ack forwarded");
    xbyte(8'h3C, 1'b0, 1'b1, 0, "R5 read data bit", "R5 master nack forwarded");
    m_scl_low = 1'b1;
    m_sda_low = 1'b0;
    waitc(10);
    sl_sda_low[0] = 1'b1;
    waitc(12);
    chk(m_sda_pd == 1'b0, "R6 slave SDA blocked after NACK", m_sda_pd, 0);
    sl_sda_low[0] = 1'b0;
    m_sda_low = 1'b1;
    waitc(4);
    m_scl_low = 1'b0;
    wait_scl_hi();
    waitc(10);
    m_sda_low = 1'b0;
    waitc(20);

    // R7 repeated START after write data, then read
    seg_sel = 2'd2; exp_mask = 4'b0100;
    waitc(5);
    bus_start();
    xbyte({7'h28, 1'b0}, 1'b1, 1'b0, 2, "R4 address bit", "R4 address ack");
    xbyte(8'h0F, 1'b1, 1'b0, 2, "R4 write bit", "R4 write ack");
    bus_rstart();
    xbyte({7'h28, 1'b1}, 1'b1, 1'b0, 2, "R7 address after repeated START", "R7 ack after repeated START");
    xbyte(8'hC3, 1'b0, 1'b1, 2, "R7 read after repeated START", "R7 nack after repeated START");
    bus_stop();

    finish_run();
  end
endmodule